// File: doc/BRIEF.md
# Interconnect Parity Self-Test Generator and Analyzer

This block exercises a set of routing wires by driving two groups of `WIDTH+1` wires and checking what comes back. Group A carries a `WIDTH`-bit counter that steps upward from zero, topped with a bit that makes the group's parity even. Group B carries a counter that steps downward from all ones, topped with a bit that makes its parity odd. Because the two counters start from complementary values, the data wires of the two groups are opposite in every cycle. A bridge between a wire of A and its partner in B then forces a visible error, and so does a wire stuck at either level.

On the receive side one analyzer flop sits on each wire pair, and two more check the parity of each received group. An analyzer sets its flop when it sees a mismatch, and the flop then stays set. A run starts with a `start` pulse, lasts exactly 2^WIDTH cycles, and ends with `done`. Afterwards `shift_en` turns the analyzer flops into a shift register, and the pass/fail map leaves on `scan_out` one bit per clock.

The wire groups are raw nets under test. They have no handshake and no back-pressure: a received value is sampled on every clock edge while the run is active. The serial result port has no back-pressure either. The reader owns the pace through `shift_en`, and a bit leaves only on an edge where `shift_en` is high.

Top module: `route_selftest`

## Requirements
- R1: After reset `running`, `done`, `fail` and `scan_out` are 0, `tx_a` is all zeros, and `tx_b` holds all ones in its data bits with its top bit equal to the odd-parity bit of that value.
- R2: `tx_a[WIDTH-1:0]` shows 0 in the first active cycle after a start and increments by one each cycle. `tx_a[WIDTH]` makes the count of ones in `tx_a` even.
- R3: `tx_b[WIDTH-1:0]` shows all ones in the first active cycle and decrements by one each cycle. `tx_b[WIDTH]` makes the count of ones in `tx_b` odd.
- R4: In every cycle `tx_b[WIDTH-1:0]` is the bitwise complement of `tx_a[WIDTH-1:0]`.
- R5: A `start` pulse while idle makes `running` high for exactly 2^WIDTH cycles. After that `running` falls and `done` rises, and `done` stays high until the next start. A `start` while running has no effect.
- R6: Pair flag i, for i < WIDTH, sets on an active cycle in which `rx_a[i]` equals `rx_b[i]`. Flag WIDTH sets when `rx_a[WIDTH]^rx_b[WIDTH]` differs from 1 if WIDTH is even, or from 0 if WIDTH is odd.
- R7: Flag WIDTH+1 sets on an active cycle in which `rx_a` has an odd number of ones. Flag WIDTH+2 sets on an active cycle in which `rx_b` has an even number of ones.
- R8: Flags are sticky. They keep their value across later clean cycles and across a new run, and only `clear`, reset or shifting changes them.
- R9: `clear` zeroes all flags on the next edge and takes priority over both capture and shift.
- R10: When `shift_en` is high and no run is active, each edge moves every flag one place toward index 0 and loads 0 into the top flag. `scan_out` always shows flag 0, so index 0 appears first. `shift_en` is ignored during a run.
- R11: `fail` is the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| clear | input | 1 | Synchronous clear of all flags |
| shift_en | input | 1 | Shift the flags toward `scan_out` |
| tx_a | output | WIDTH+1 | Up count with even parity on top |
| tx_b | output | WIDTH+1 | Down count with odd parity on top |
| rx_a | input | WIDTH+1 | Group A as received from the wires |
| rx_b | input | WIDTH+1 | Group B as received from the wires |
| running | output | 1 | Run active |
| done | output | 1 | Run finished |
| scan_out | output | 1 | Flag 0 (serial result) |
| fail | output | 1 | Any flag set |

## Verification
The in-line assertions check the following on every cycle:
- the complement relation between the two counters;
- the parity of each driven group;
- the end of a run after the last count;
- flag stickiness, the priority of clear, and the one-place shift.

Only the bench's scenarios can show that a particular fault sets exactly the flags predicted for it. To do that, the bench injects every single stuck-at fault on every wire, plus wired-AND bridges between partner wires, and then reads the whole flag map back serially.

// File: rtl/route_selftest_pkg.sv
package route_selftest_pkg;
  function automatic int flag_count(input int width);
    return width + 3;
  endfunction
endpackage

// File: rtl/rst_pattern_gen.sv
module rst_pattern_gen #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             running,
  output logic             done,
  output logic [WIDTH-1:0] up_q,
  output logic [WIDTH-1:0] dn_q
);
  localparam logic [WIDTH-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q    <= '0;
      dn_q    <= '1;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (running) begin
      if (up_q == LAST) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        up_q <= up_q + 1'b1;
        dn_q <= dn_q - 1'b1;
      end
    end else if (start) begin
      running <= 1'b1;
      done    <= 1'b0;
      up_q    <= '0;
      dn_q    <= '1;
    end
  end

  // R4
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_q == ~up_q);

  // R5
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && up_q == LAST |=> done && !running);

  // R5
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && start && up_q != LAST |=> running && up_q == $past(up_q) + 1'b1);
endmodule

// File: rtl/rst_ora_cell.sv
module rst_ora_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic capture,
  input  logic shift,
  input  logic miss,
  input  logic shift_in,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) q <= 1'b0;
    else if (shift)      q <= shift_in;
    else if (capture)    q <= q | miss;
  end

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q && !clear && !shift |=> q);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !q);

  // R10
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift && !clear |=> q == $past(shift_in));
endmodule

// File: rtl/route_selftest.sv
module route_selftest
  import route_selftest_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic             shift_en,
  output logic [WIDTH:0]   tx_a,
  output logic [WIDTH:0]   tx_b,
  input  logic [WIDTH:0]   rx_a,
  input  logic [WIDTH:0]   rx_b,
  output logic             running,
  output logic             done,
  output logic             scan_out,
  output logic             fail
);
  localparam int   FLAGS  = flag_count(WIDTH);
  localparam logic PAR_XR = (WIDTH % 2 == 0);

  logic [WIDTH-1:0] up_q, dn_q;
  logic [FLAGS-1:0] miss, flag_q;
  logic             shift;

  rst_pattern_gen #(.WIDTH(WIDTH)) i_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .running(running), .done(done), .up_q(up_q), .dn_q(dn_q)
  );

  assign tx_a  = {^up_q, up_q};
  assign tx_b  = {~^dn_q, dn_q};
  assign shift = shift_en & ~running;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) miss[i] = ~(rx_a[i] ^ rx_b[i]);
    miss[WIDTH]   = (rx_a[WIDTH] ^ rx_b[WIDTH]) != PAR_XR;
    miss[WIDTH+1] = ^rx_a;
    miss[WIDTH+2] = ~^rx_b;
  end

  for (genvar g = 0; g < FLAGS; g++) begin : g_cell
    logic sin;
    if (g == FLAGS - 1) begin : g_top
      assign sin = 1'b0;
    end else begin : g_mid
      assign sin = flag_q[g+1];
    end
    rst_ora_cell i_cell (
      .clk(clk), .rst_n(rst_n), .clear(clear), .capture(running),
      .shift(shift), .miss(miss[g]), .shift_in(sin), .q(flag_q[g])
    );
  end

  assign scan_out = flag_q[0];
  assign fail     = |flag_q;

  // R2
  even_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(^tx_a));

  // R3
  odd_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ^tx_b);

  // R10
  hold_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !clear && shift_en |=> (flag_q & $past(flag_q)) == $past(flag_q));
endmodule

// File: tb/test_route_selftest.sv
module test_route_selftest;
  localparam int W = 4;
  localparam int F = W + 3;
  localparam int RUN = 1 << W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clear = 1'b0, shift_en = 1'b0;
  logic [W:0] tx_a, tx_b, rx_a, rx_b;
  logic running, done, scan_out, fail;
  logic [W:0] sa0_a = '0, sa1_a = '0, sa0_b = '0, sa1_b = '0, br = '0;
  int n_chk = 0, n_fail = 0;
  logic [F-1:0] exp_f = '0;

  always #4 clk = ~clk;

  route_selftest #(.WIDTH(W)) i_route_selftest (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .shift_en(shift_en),
    .tx_a(tx_a), .tx_b(tx_b), .rx_a(rx_a), .rx_b(rx_b),
    .running(running), .done(done), .scan_out(scan_out), .fail(fail)
  );

  function automatic logic [2*W+1:0] wires(input logic [W:0] a, input logic [W:0] b);
    logic [W:0] ra, rb, wa;
    wa = a & b;
    ra = (((a & ~br) | (wa & br)) & ~sa0_a) | sa1_a;
    rb = (((b & ~br) | (wa & br)) & ~sa0_b) | sa1_b;
    return {ra, rb};
  endfunction

  always_comb {rx_a, rx_b} = wires(tx_a, tx_b);

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [F-1:0] flags_for(input logic [W:0] a, input logic [W:0] b);
    logic [2*W+1:0] r;
    logic [W:0] ra, rb;
    logic [F-1:0] f;
    r = wires(a, b);
    ra = r[2*W+1:W+1];
    rb = r[W:0];
    for (int i = 0; i < W; i++) f[i] = (ra[i] == rb[i]);
    f[W]   = ((ra[W] ^ rb[W]) != ((W % 2) == 0));
    f[W+1] = ($countones(ra) % 2) == 1;
    f[W+2] = ($countones(rb) % 2) == 0;
    return f;
  endfunction

  // One run; restart_at / shift_upto / clear_at pick optional side stimulus.
  task automatic do_run(input int restart_at, input int shift_upto, input int clear_at);
    start = 1'b1;
    for (int k = 0; k < RUN; k++) begin
      logic [W-1:0] ua, db;
      logic [W:0] ea, eb;
      @(negedge clk);
      start    = (k == restart_at);
      shift_en = (k < shift_upto);
      clear    = (k == clear_at);
      ua = W'(k);
      db = ~W'(k);
      ea = {^ua, ua};
      eb = {~^db, db};
      chk(tx_a == ea, "R2", tx_a, ea);
      chk(tx_b == eb, "R3", tx_b, eb);
      chk(tx_b[W-1:0] == ~tx_a[W-1:0], "R4", tx_b, ~tx_a);
      chk(running == 1'b1, "R5", running, 1);
      if (k == clear_at) exp_f = '0;
      else exp_f = exp_f | flags_for(ea, eb);
    end
    @(negedge clk);
    start = 1'b0; shift_en = 1'b0; clear = 1'b0;
    chk(running == 1'b0 && done == 1'b1, "R5", {running, done}, 1);
    @(negedge clk);
    chk(done == 1'b1 && running == 1'b0, "R5", {running, done}, 1);
    chk(fail == |exp_f, "R11", fail, |exp_f);
  endtask

  task automatic read_out();
    for (int i = 0; i < F; i++) begin
      chk(scan_out == exp_f[i], "R6 R7 R10", scan_out, exp_f[i]);
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
    chk(fail == 1'b0, "R10", fail, 0);
    exp_f = '0;
  endtask

  task automatic clr();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    exp_f = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({running, done, fail, scan_out} == 4'b0, "R1", {running, done, fail, scan_out}, 0);
    chk(tx_a == '0, "R1", tx_a, 0);
    chk(tx_b == {~^W'('1), W'('1)}, "R1", tx_b, {~^W'('1), W'('1)});
    rst_n = 1'b1;
    @(negedge clk);

    // Clean run; R5 restart inside the run is ignored
    do_run(5, 0, -1);
    chk(fail == 1'b0, "R6", fail, 0);

    // Every single stuck-at fault, each polarity, each wire of each group
    for (int grp = 0; grp < 2; grp++)
      for (int pol = 0; pol < 2; pol++)
        for (int w = 0; w <= W; w++) begin
          logic [W:0] m;
          m = (W+1)'(1) << w;
          sa0_a = (grp == 0 && pol == 0) ? m : '0;
          sa1_a = (grp == 0 && pol == 1) ? m : '0;
          sa0_b = (grp == 1 && pol == 0) ? m : '0;
          sa1_b = (grp == 1 && pol == 1) ? m : '0;
          do_run(-1, 0, -1);
          chk(exp_f[w] == 1'b1 && fail, "R6", fail, 1);
          read_out();
        end
    sa0_a = '0; sa1_a = '0; sa0_b = '0; sa1_b = '0;

    // Wired-AND bridges between partner wires; shift_en held during run (R10)
    for (int w = 0; w <= W; w++) begin
      br = (W+1)'(1) << w;
      do_run(-1, RUN - 1, -1);
      read_out();
    end

    // R8: flag survives a later clean run without clear
    br = (W+1)'(1) << 1;
    do_run(-1, 0, -1);
    br = '0;
    do_run(-1, 0, -1);
    chk(fail == 1'b1, "R8", fail, 1);
    read_out();

    // R9: clear on the last active cycle beats capture
    sa1_b = (W+1)'(1) << 0;
    do_run(-1, 0, RUN - 1);
    chk(fail == 1'b0, "R9", fail, 0);
    // R9: clear beats shift
    do_run(-1, 0, -1);
    clear = 1'b1; shift_en = 1'b1;
    @(negedge clk);
    clear = 1'b0; shift_en = 1'b0;
    exp_f = '0;
    chk(fail == 1'b0 && scan_out == 1'b0, "R9", fail, 0);
    sa1_b = '0;

    // R8: idle cycles hold flags
    br = '1;
    do_run(-1, 0, -1);
    br = '0;
    repeat (5) @(negedge clk);
    chk(fail == 1'b1, "R8", fail, 1);
    read_out();
    clr();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule